// File: doc/BRIEF.md
# Operand Addressing Mode Resolver

This block turns the register number and addressing-mode bits of one operand field of a 16-bit instruction into a resolved operand descriptor: a kind code, the register index and a 20-bit value. A source operand carries a 2-bit mode. A destination operand carries a 1-bit mode, taken from bit 0 of the mode input. Some register and mode pairs do not address a register at all. They select a built-in constant, an address relative to the current word, or an absolute address.

When the selected mode needs an extension word, the block requests one 16-bit word through a valid/ready fetch port, at the address it was handed with the request. It then folds that word into the result. An optional 4-bit prefix supplies value bits 19:16 above a fetched word. The caller starts one resolution at a time with a start strobe. A single-cycle done pulse marks the result, together with the number of words consumed (0 or 1).

Top module: `opres_top`

## Requirements
- R1: Source mode 0: register 3 gives kind CONST (0) with value 0. Any other register gives kind REG (1) with value 0. No word is fetched.
- R2: Source mode 1 fetches one word. Register 0 gives kind ABS (3) with value word plus fetch address. Register 2 gives ABS with value word. Register 3 gives CONST with value 1 and fetches nothing. Any other register gives kind INDEX (2) with value word.
- R3: Source mode 2 fetches no word. Register 2 gives CONST 4 and register 3 gives CONST 2. Any other register gives kind IND (4) with value 0.
- R4: Source mode 3: register 0 fetches a word and gives CONST with value word. Register 2 gives CONST 8. Register 3 gives CONST 0xFFFFF, which is -1 sign-extended to 20 bits. Any other register gives kind INC (5) with value 0.
- R5: A destination operand (src_i low) uses only mode bit 0. Mode 0 gives REG with value 0 for every register, including 2 and 3. Mode 1 fetches a word and gives ABS relative to the fetch address (register 0), ABS with value word (register 2), or INDEX (every other register, including 3).
- R6: With pfx_en_i high at start, pfx_i fills bits 19:16 of a fetched word before any addition. Without it, those bits are 0. The prefix never changes a constant that needs no fetch.
- R7: The fetched word is little-endian: fetch_data_i[7:0] is the byte at fetch_addr_o and forms word bits 7:0, and fetch_data_i[15:8] forms bits 15:8.
- R8: The address-relative value is the 20-bit extended word plus fetch_addr_o, taken modulo 2^20.
- R9: fetch_valid_o rises only for the modes that need a word. It then stays high, with fetch_addr_o equal to the start address and stable, until a cycle with fetch_ready_i high. words_o is 1 exactly when a word was taken.
- R10: done_o pulses for one cycle. Without a fetch it comes on the cycle after the start edge; with a fetch, on the cycle after the handshake edge. reg_o echoes the requested register.
- R11: A start_i strobe while a fetch is pending is ignored, as are input changes during that time, and the pending result is unaffected.
- R12: After reset, done_o and fetch_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a resolution (accepted only when idle) |
| src_i | input | 1 | 1 = source operand, 0 = destination operand |
| reg_i | input | 4 | Register number |
| mode_i | input | 2 | Addressing mode (destination uses bit 0) |
| pfx_en_i | input | 1 | Extension prefix present |
| pfx_i | input | 4 | Prefix bits placed at value 19:16 |
| addr_i | input | 20 | Address of the extension word |
| fetch_valid_o | output | 1 | Word fetch request |
| fetch_addr_o | output | 20 | Address of the requested word |
| fetch_ready_i | input | 1 | Fetch data valid this cycle |
| fetch_data_i | input | 16 | Fetched bytes, lower address in bits 7:0 |
| done_o | output | 1 | Result valid pulse |
| kind_o | output | 3 | Operand kind code |
| reg_o | output | 4 | Register index |
| value_o | output | 20 | Constant, offset or address |
| words_o | output | 1 | Extension words consumed |

## Verification
A wrong decode choice shows on the next done pulse as a bad kind code, a bad value or a bad word count. A stray fetch request or a missing one shows in the very cycle after the start edge. A captured operand corrupted while a fetch is pending shows only when the handshake completes. For that reason the bench holds the ready line low for random spans and toggles the start strobe and operand inputs during the wait. The symbolic sum and the prefix placement are checked against bench-computed values over random addresses and words, so a carry or bit-position error shows on the first affected operand.

// File: rtl/opres_pkg.sv
package opres_pkg;
  typedef enum logic [2:0] {
    OPK_CONST = 3'd0,
    OPK_REG   = 3'd1,
    OPK_INDEX = 3'd2,
    OPK_ABS   = 3'd3,
    OPK_IND   = 3'd4,
    OPK_INC   = 3'd5
  } opk_e;

  // how the final value is formed
  typedef enum logic [1:0] {
    VSEL_ZERO  = 2'd0,
    VSEL_CONST = 2'd1,
    VSEL_WORD  = 2'd2,
    VSEL_REL   = 2'd3
  } vsel_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } st_e;
endpackage

// File: rtl/opres_mode_decode.sv
module opres_mode_decode
  import opres_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int VAL_W = 20
) (
  input  logic             src_i,
  input  logic [REG_W-1:0] reg_i,
  input  logic [1:0]       mode_i,
  output opk_e             kind_o,
  output vsel_e            vsel_o,
  output logic             need_word_o,
  output logic [VAL_W-1:0] const_o
);
  localparam logic [REG_W-1:0] R_PC = REG_W'(0);
  localparam logic [REG_W-1:0] R_SR = REG_W'(2);
  localparam logic [REG_W-1:0] R_CG = REG_W'(3);

  function automatic logic [VAL_W-1:0] cval(input int v);
    return VAL_W'(v);
  endfunction

  always_comb begin
    kind_o      = OPK_REG;
    vsel_o      = VSEL_ZERO;
    need_word_o = 1'b0;
    const_o     = '0;
    if (src_i) begin
      unique case (mode_i)
        2'b00: begin
          if (reg_i == R_CG) begin
            kind_o = OPK_CONST; vsel_o = VSEL_CONST; const_o = cval(0);
          end
        end
        2'b01: begin
          if (reg_i == R_CG) begin
            kind_o = OPK_CONST; vsel_o = VSEL_CONST; const_o = cval(1);
          end else begin
            need_word_o = 1'b1;
            if (reg_i == R_PC) begin
              kind_o = OPK_ABS; vsel_o = VSEL_REL;
            end else if (reg_i == R_SR) begin
              kind_o = OPK_ABS; vsel_o = VSEL_WORD;
            end else begin
              kind_o = OPK_INDEX; vsel_o = VSEL_WORD;
            end
          end
        end
        2'b10: begin
          if (reg_i == R_SR) begin
            kind_o = OPK_CONST; vsel_o = VSEL_CONST; const_o = cval(4);
          end else if (reg_i == R_CG) begin
            kind_o = OPK_CONST; vsel_o = VSEL_CONST; const_o = cval(2);
          end else begin
            kind_o = OPK_IND;
          end
        end
        default: begin
          if (reg_i == R_PC) begin
            kind_o = OPK_CONST; vsel_o = VSEL_WORD; need_word_o = 1'b1;
          end else if (reg_i == R_SR) begin
            kind_o = OPK_CONST; vsel_o = VSEL_CONST; const_o = cval(8);
          end else if (reg_i == R_CG) begin
            kind_o = OPK_CONST; vsel_o = VSEL_CONST; const_o = '1;
          end else begin
            kind_o = OPK_INC;
          end
        end
      endcase
    end else if (mode_i[0]) begin
      need_word_o = 1'b1;
      if (reg_i == R_PC) begin
        kind_o = OPK_ABS; vsel_o = VSEL_REL;
      end else if (reg_i == R_SR) begin
        kind_o = OPK_ABS; vsel_o = VSEL_WORD;
      end else begin
        kind_o = OPK_INDEX; vsel_o = VSEL_WORD;
      end
    end
  end
endmodule

// File: rtl/opres_word_join.sv
module opres_word_join #(
  parameter int WORD_W = 16,
  parameter int PFX_W  = 4,
  parameter int VAL_W  = WORD_W + PFX_W
) (
  input  logic [WORD_W-1:0] bytes_i,
  input  logic              pfx_en_i,
  input  logic [PFX_W-1:0]  pfx_i,
  input  logic [VAL_W-1:0]  base_i,
  input  logic              rel_i,
  output logic [VAL_W-1:0]  value_o
);
  localparam int NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] word;
  logic [VAL_W-1:0]  ext_word;

  // lane k holds the byte at base + k
  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    assign word[8*k +: 8] = bytes_i[8*k +: 8];
  end

  assign ext_word = {(pfx_en_i ? pfx_i : {PFX_W{1'b0}}), word};
  assign value_o  = rel_i ? (ext_word + base_i) : ext_word;
endmodule

// File: rtl/opres_top.sv
module opres_top
  import opres_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int WORD_W = 16,
  parameter int PFX_W  = 4,
  parameter int VAL_W  = WORD_W + PFX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              src_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [1:0]        mode_i,
  input  logic              pfx_en_i,
  input  logic [PFX_W-1:0]  pfx_i,
  input  logic [VAL_W-1:0]  addr_i,
  output logic              fetch_valid_o,
  output logic [VAL_W-1:0]  fetch_addr_o,
  input  logic              fetch_ready_i,
  input  logic [WORD_W-1:0] fetch_data_i,
  output logic              done_o,
  output logic [2:0]        kind_o,
  output logic [REG_W-1:0]  reg_o,
  output logic [VAL_W-1:0]  value_o,
  output logic              words_o
);
  st_e               st_q;
  opk_e              dec_kind, kind_q;
  vsel_e             dec_vsel, vsel_q;
  logic              dec_need;
  logic [VAL_W-1:0]  dec_const;
  logic [VAL_W-1:0]  join_val;
  logic [VAL_W-1:0]  addr_q, value_q;
  logic [REG_W-1:0]  reg_q;
  logic              pfx_en_q, done_q, words_q;
  logic [PFX_W-1:0]  pfx_q;
  logic              accept, take;

  opres_mode_decode #(.REG_W(REG_W), .VAL_W(VAL_W)) u_dec (
    .src_i      (src_i),
    .reg_i      (reg_i),
    .mode_i     (mode_i),
    .kind_o     (dec_kind),
    .vsel_o     (dec_vsel),
    .need_word_o(dec_need),
    .const_o    (dec_const)
  );

  opres_word_join #(.WORD_W(WORD_W), .PFX_W(PFX_W), .VAL_W(VAL_W)) u_join (
    .bytes_i (fetch_data_i),
    .pfx_en_i(pfx_en_q),
    .pfx_i   (pfx_q),
    .base_i  (addr_q),
    .rel_i   (vsel_q == VSEL_REL),
    .value_o (join_val)
  );

  assign accept = (st_q == ST_IDLE) && start_i;
  assign take   = (st_q == ST_FETCH) && fetch_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      kind_q   <= OPK_REG;
      vsel_q   <= VSEL_ZERO;
      addr_q   <= '0;
      reg_q    <= '0;
      pfx_en_q <= 1'b0;
      pfx_q    <= '0;
      value_q  <= '0;
      done_q   <= 1'b0;
      words_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        kind_q   <= dec_kind;
        vsel_q   <= dec_vsel;
        addr_q   <= addr_i;
        reg_q    <= reg_i;
        pfx_en_q <= pfx_en_i;
        pfx_q    <= pfx_i;
        if (dec_need) begin
          st_q <= ST_FETCH;
        end else begin
          value_q <= (dec_vsel == VSEL_CONST) ? dec_const : '0;
          words_q <= 1'b0;
          done_q  <= 1'b1;
        end
      end else if (take) begin
        st_q    <= ST_IDLE;
        value_q <= join_val;
        words_q <= 1'b1;
        done_q  <= 1'b1;
      end
    end
  end

  assign fetch_valid_o = (st_q == ST_FETCH);
  assign fetch_addr_o  = addr_q;
  assign done_o        = done_q;
  assign kind_o        = kind_q;
  assign reg_o         = reg_q;
  assign value_o       = value_q;
  assign words_o       = words_q;
endmodule

// File: rtl/opres_checker.sv
module opres_checker #(
  parameter int VAL_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             fetch_valid_o,
  input logic [VAL_W-1:0] fetch_addr_o,
  input logic             fetch_ready_i,
  input logic             done_o,
  input logic [2:0]       kind_o,
  input logic [VAL_W-1:0] value_o,
  input logic             words_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o && !fetch_ready_i |=> fetch_valid_o && $stable(fetch_addr_o)); // R9
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o && fetch_ready_i |=> !fetch_valid_o && done_o && words_o); // R10
  AST_WORD_HAD_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && words_o |-> $past(fetch_valid_o && fetch_ready_i)); // R9
  AST_NO_DONE_WHILE_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o |-> !done_o); // R11
  AST_PLAIN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (kind_o == 3'd1 || kind_o == 3'd4 || kind_o == 3'd5) |-> value_o == '0 && !words_o); // R1
  AST_KIND_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> kind_o <= 3'd5); // R10
  AST_START_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_o && start_i |=> done_o || fetch_valid_o); // R10
endmodule

bind opres_top opres_checker #(.VAL_W(VAL_W)) u_opres_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .fetch_valid_o(fetch_valid_o),
  .fetch_addr_o (fetch_addr_o),
  .fetch_ready_i(fetch_ready_i),
  .done_o       (done_o),
  .kind_o       (kind_o),
  .value_o      (value_o),
  .words_o      (words_o)
);

// File: tb/opres_top_bench.sv
module opres_top_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, src_i = 1'b0, pfx_en_i = 1'b0;
  logic [3:0]  reg_i = '0, pfx_i = '0;
  logic [1:0]  mode_i = '0;
  logic [19:0] addr_i = '0;
  logic        fetch_ready_i = 1'b0;
  logic [15:0] fetch_data_i = '0;
  logic        fetch_valid_o, done_o, words_o;
  logic [19:0] fetch_addr_o, value_o;
  logic [2:0]  kind_o;
  logic [3:0]  reg_o;
  int checks = 0, errors = 0;

  opres_top u_opres_top (.*);

  always #10 clk_i = ~clk_i;

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected {kind, value, words, needs_fetch}
  function automatic logic [24:0] model(input logic s, input logic [3:0] r, input logic [1:0] m,
                                        input logic pe, input logic [3:0] p,
                                        input logic [19:0] a, input logic [15:0] w);
    logic [19:0] xw;
    xw = {pe ? p : 4'd0, w};
    if (s) begin
      case (m)
        2'd0: return (r == 3) ? {3'd0, 20'd0, 2'b00} : {3'd1, 20'd0, 2'b00};
        2'd1: begin
          if (r == 3) return {3'd0, 20'd1, 2'b00};
          if (r == 0) return {3'd3, xw + a, 2'b11};
          if (r == 2) return {3'd3, xw, 2'b11};
          return {3'd2, xw, 2'b11};
        end
        2'd2: begin
          if (r == 2) return {3'd0, 20'd4, 2'b00};
          if (r == 3) return {3'd0, 20'd2, 2'b00};
          return {3'd4, 20'd0, 2'b00};
        end
        default: begin
          if (r == 0) return {3'd0, xw, 2'b11};
          if (r == 2) return {3'd0, 20'd8, 2'b00};
          if (r == 3) return {3'd0, 20'hFFFFF, 2'b00};
          return {3'd5, 20'd0, 2'b00};
        end
      endcase
    end
    if (!m[0]) return {3'd1, 20'd0, 2'b00};
    if (r == 0) return {3'd3, xw + a, 2'b11};
    if (r == 2) return {3'd3, xw, 2'b11};
    return {3'd2, xw, 2'b11};
  endfunction

  task automatic run_op(input logic s, input logic [3:0] r, input logic [1:0] m,
                        input logic pe, input logic [3:0] p, input logic [19:0] a,
                        input logic [15:0] w, input int hold, input logic noise, input string tag);
    logic [24:0] e;
    int waited = 0;
    logic fetched = 1'b0;
    e = model(s, r, m, pe, p, a, w);
    @(negedge clk_i);
    start_i = 1'b1; src_i = s; reg_i = r; mode_i = m; pfx_en_i = pe; pfx_i = p; addr_i = a;
    @(negedge clk_i);
    start_i = 1'b0;
    if (!e[1]) begin
      chk({tag, " R10 done after start"}, done_o, 1'b1);
      chk({tag, " R9 no request"}, fetch_valid_o, 1'b0);
    end else begin
      chk({tag, " R9 request"}, fetch_valid_o, 1'b1);
      while (waited < hold) begin
        chk({tag, " R9 addr"}, fetch_addr_o, a);
        chk({tag, " R11 no early done"}, done_o, 1'b0);
        if (noise) begin  // R11
          start_i = 1'b1; src_i = ~s; reg_i = ~r; mode_i = ~m; pfx_en_i = ~pe; addr_i = ~a;
        end
        @(negedge clk_i);
        start_i = 1'b0;
        waited++;
      end
      chk({tag, " R9 held"}, fetch_valid_o, 1'b1);
      chk({tag, " R9 addr"}, fetch_addr_o, a);
      fetch_ready_i = 1'b1; fetch_data_i = w;  // R7 lane 0 = low byte
      @(negedge clk_i);
      fetch_ready_i = 1'b0; fetch_data_i = $urandom;
      fetched = 1'b1;
      chk({tag, " R10 done after take"}, done_o, 1'b1);
      chk({tag, " R9 drop"}, fetch_valid_o, 1'b0);
    end
    chk({tag, " kind"}, kind_o, e[24:22]);
    chk({tag, " value R8 R6"}, value_o, e[21:2]);
    chk({tag, " R9 words"}, words_o, fetched);
    chk({tag, " R10 reg"}, reg_o, r);
    @(negedge clk_i);
    chk({tag, " R10 pulse"}, done_o, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0A1D));
    #25;
    chk("R12 done", done_o, 1'b0);
    chk("R12 req", fetch_valid_o, 1'b0);
    rst_ni = 1'b1;
    // directed sweep over all source and destination pairs
    for (int r = 0; r < 16; r++)
      for (int m = 0; m < 4; m++) begin
        run_op(1'b1, 4'(r), 2'(m), 1'b0, 4'h0, 20'h01230, 16'hA55A, 1, 1'b0,
               m == 0 ? "R1" : m == 1 ? "R2" : m == 2 ? "R3" : "R4");
        run_op(1'b0, 4'(r), 2'(m), 1'b0, 4'h0, 20'h00100, 16'h1234, 0, 1'b0, "R5");
      end
    // corners: R4 immediate with prefix, R8 wrap, R6 prefix on constant, R7 byte order
    run_op(1'b1, 4'd0, 2'd3, 1'b1, 4'hB, 20'h0, 16'h00FF, 0, 1'b0, "R6 imm");
    run_op(1'b1, 4'd0, 2'd1, 1'b1, 4'hF, 20'hFFFFE, 16'hFFFF, 2, 1'b1, "R8 wrap");
    run_op(1'b1, 4'd3, 2'd3, 1'b1, 4'h7, 20'h0, 16'h0, 0, 1'b0, "R6 const");
    run_op(1'b1, 4'd2, 2'd1, 1'b0, 4'h9, 20'h4, 16'h8001, 3, 1'b1, "R7");
    // constrained random
    for (int i = 0; i < 400; i++)
      run_op(1'($urandom), 4'($urandom), 2'($urandom), 1'($urandom), 4'($urandom),
             20'($urandom), 16'($urandom), int'($urandom % 4), 1'($urandom), "rand");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule